// File: doc/BRIEF.md
# Dual-Byte Down-Counter Timer

A 16-bit programmable timer with a byte-wide register port. Software loads a reload value as two separate bytes and picks an operating mode and an input tick rate in a control byte. It then starts the counter by writing that control byte a second time with the run bit set. The counter steps down once per selected tick. When it reaches its terminal count, the block drives its output according to the mode and can latch an interrupt flag.

In normal operation, reads of the two data addresses return the reload bytes. When the snapshot bit in the control byte is set, those addresses return a copy of the counter taken at the moment of the control write. Both bytes of that copy therefore come from the same instant. The output and the interrupt each have a polarity bit.

Top module: `dual_byte_timer`

## Requirements
- R1: After reset, addresses 0, 1 and 2 read 0x00 and address 3 reads 0x06. tmr_o and irq_o are low.
- R2: Register map. Address 0 holds the reload low byte and address 1 holds the reload high byte. Address 2 is the control byte: mode in [1:0] (0 single-shot, 1 rate, 2 square, 3 retriggerable), tick select in [3:2], run in [4], snapshot in [5], and [7:6] read as zero. Address 3 is the aux byte: irq enable in [0], output polarity in [1], irq polarity in [2], and the flag in [7]. With snapshot clear, addresses 0 and 1 read back the reload bytes.
- R3: A control write with run=1 sets run only if its mode and tick select equal the stored ones. Otherwise the new value is stored with run=0. A 0-to-1 change of run loads the reload value into the counter and clears the output state.
- R4: The counter steps down on every tick. Ticks come every 1, 4, 16 or 64 clocks for tick select 0 to 3, counted from the start edge. The terminal event is the tick that finds the count at 1 or 0, so it comes max(N,1)·P clocks after the start.
- R5: Single-shot mode. At the terminal event the count becomes 0, the output goes active and stays active, and the run bit clears.
- R6: Rate mode. The counter reloads at each terminal event, and the output is active for exactly one clock after each event.
- R7: Square mode. The counter reloads at each terminal event, and the output toggles at each event.
- R8: Retriggerable mode. Starting only arms the timer. Each rising edge of trig_i reloads the counter and drives the output active. The output goes inactive at the terminal event.
- R9: A control write with snapshot=1 copies the current count into a snapshot register. While snapshot is set, addresses 0 and 1 return the low and high bytes of that copy.
- R10: While run is 0, the count holds its value.
- R11: The flag (aux bit 7) is set at a terminal event only when irq enable is 1. Writing aux with bit 7 = 1 clears the flag.
- R12: tmr_o equals the output state when output polarity is 1 and its inverse when it is 0. irq_o relates to the flag the same way through irq polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| trig_i | input | 1 | Hardware trigger for retriggerable mode |
| tmr_o | output | 1 | Timer output after polarity |
| irq_o | output | 1 | Interrupt flag after polarity |

## Verification
The bench uses the default tap spacing of two prescaler bits. This gives tick periods of 1, 4, 16 and 64 clocks. Every tick select can then reach its terminal event within a few hundred clocks, so the vector table checks each divider with small reload values. It also checks the zero reload and a reload above 255 that uses the high byte. Directed cases use a period of one clock, so the timing of snapshot, halt, retrigger and toggle is exact to the clock edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    TM_ONESHOT = 2'd0,
    TM_RATE    = 2'd1,
    TM_SQUARE  = 2'd2,
    TM_RETRIG  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic [1:0] spare;
    logic       rd;
    logic       run;
    logic [1:0] clk_sel;
    tmr_mode_e  mode;
  } tmr_ctrl_t;

  localparam logic [1:0] A_LSB  = 2'd0;
  localparam logic [1:0] A_MSB  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_AUX  = 2'd3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned TAP_STEP = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned NSEL  = 4;
  localparam int unsigned PRE_W = TAP_STEP * (NSEL - 1);

  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  taps;

  // held at zero while stopped so the first tick is a fixed distance from start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    if (k == 0) begin : g_direct
      assign taps[k] = 1'b1;
    end else begin : g_div
      // falling edge of bit k*TAP_STEP-1 is the cycle its lower bits are all ones
      assign taps[k] = &pre_q[k*TAP_STEP-1:0];
    end
  end

  assign tick_o = run_i & taps[sel_i];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             trig_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_act_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q, out_q, trig_q, trig_rise, evt;

  assign trig_rise = trig_i & ~trig_q & run_i & (mode_i == TM_RETRIG);
  assign evt = tick_i & active_q & (cnt_q <= CNT_W'(1)) & ~start_i & ~trig_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      out_q    <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= reload_i;
      active_q <= (mode_i != TM_RETRIG);
      out_q    <= 1'b0;
    end else if (trig_rise) begin
      cnt_q    <= reload_i;
      active_q <= 1'b1;
      out_q    <= 1'b1;
    end else begin
      if (mode_i == TM_RATE) out_q <= evt;
      if (tick_i && active_q) begin
        if (evt) begin
          case (mode_i)
            TM_ONESHOT: begin cnt_q <= '0; active_q <= 1'b0; out_q <= 1'b1; end
            TM_RATE:    cnt_q <= reload_i;
            TM_SQUARE:  begin cnt_q <= reload_i; out_q <= ~out_q; end
            default:    begin cnt_q <= '0; active_q <= 1'b0; out_q <= 1'b0; end
          endcase
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign out_act_o = out_q;
  assign evt_o     = evt;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              evt_i,
  output tmr_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              start_o,
  output logic              irq_en_o,
  output logic              out_pol_o,
  output logic              irq_pol_o,
  output logic              flag_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] lsb_q, msb_q;
  logic [CNT_W-1:0]  snap_q;
  tmr_ctrl_t         ctrl_q, wctrl;
  logic              irq_en_q, out_pol_q, irq_pol_q, flag_q;
  logic              wr_ctrl, wr_aux, cfg_match;

  assign wctrl     = tmr_ctrl_t'(wdata_i);
  assign wr_ctrl   = we_i && (addr_i == A_CTRL);
  assign wr_aux    = we_i && (addr_i == A_AUX);
  assign cfg_match = (wctrl.mode == ctrl_q.mode) && (wctrl.clk_sel == ctrl_q.clk_sel);
  assign start_o   = wr_ctrl && wctrl.run && !ctrl_q.run && cfg_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q <= '0;
      msb_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_LSB) lsb_q <= wdata_i;
      if (addr_i == A_MSB) msb_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      snap_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q       <= wctrl;
      ctrl_q.spare <= '0;
      ctrl_q.run   <= wctrl.run && cfg_match;
      if (wctrl.rd) snap_q <= cnt_i;
    end else if (evt_i && ctrl_q.mode == TM_ONESHOT) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q  <= 1'b0;
      out_pol_q <= 1'b1;
      irq_pol_q <= 1'b1;
      flag_q    <= 1'b0;
    end else begin
      if (wr_aux) begin
        irq_en_q  <= wdata_i[0];
        out_pol_q <= wdata_i[1];
        irq_pol_q <= wdata_i[2];
      end
      if (evt_i && irq_en_q)         flag_q <= 1'b1;
      else if (wr_aux && wdata_i[7]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_LSB:   rdata_o = ctrl_q.rd ? snap_q[BYTE_W-1:0] : lsb_q;
      A_MSB:   rdata_o = ctrl_q.rd ? snap_q[CNT_W-1:BYTE_W] : msb_q;
      A_CTRL:  rdata_o = ctrl_q;
      default: rdata_o = {flag_q, 4'b0000, irq_pol_q, out_pol_q, irq_en_q};
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign reload_o  = {msb_q, lsb_q};
  assign irq_en_o  = irq_en_q;
  assign out_pol_o = out_pol_q;
  assign irq_pol_o = irq_pol_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/dual_byte_timer.sv
module dual_byte_timer
  import tmr_pkg::*;
#(
  parameter int unsigned TAP_STEP = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       trig_i,
  output logic       tmr_o,
  output logic       irq_o
);
  tmr_ctrl_t        ctrl_w;
  tmr_mode_e        mode_w;
  logic [CNT_W-1:0] reload_w, cnt_w;
  logic             run_w, start_w, tick_w, evt_w, out_act_w;
  logic             irq_en_w, out_pol_w, irq_pol_w, flag_w;

  assign run_w  = ctrl_w.run;
  assign mode_w = ctrl_w.mode;

  tmr_regs u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt_w), .evt_i(evt_w), .ctrl_o(ctrl_w), .reload_o(reload_w),
    .start_o(start_w), .irq_en_o(irq_en_w), .out_pol_o(out_pol_w),
    .irq_pol_o(irq_pol_w), .flag_o(flag_w), .rdata_o
  );

  tmr_prescaler #(.TAP_STEP(TAP_STEP)) u_pre (
    .clk_i, .rst_ni, .run_i(run_w), .sel_i(ctrl_w.clk_sel), .tick_o(tick_w)
  );

  tmr_core u_core (
    .clk_i, .rst_ni, .run_i(run_w), .start_i(start_w), .tick_i(tick_w),
    .mode_i(mode_w), .reload_i(reload_w), .trig_i,
    .cnt_o(cnt_w), .out_act_o(out_act_w), .evt_o(evt_w)
  );

  assign tmr_o = out_pol_w ? out_act_w : ~out_act_w;
  assign irq_o = irq_pol_w ? flag_w : ~flag_w;
endmodule

// File: rtl/dual_byte_timer_chk.sv
module dual_byte_timer_chk
  import tmr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             start_i,
  input logic             evt_i,
  input tmr_mode_e        mode_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             out_act_i,
  input logic             irq_en_i,
  input logic             flag_i
);
  // R3
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_i == $past(reload_i));
  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(cnt_i));
  // R4
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && !evt_i && mode_i != TM_RETRIG) |=>
      (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) - 1'b1));
  // R5
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && mode_i == TM_ONESHOT) |=> (!run_i && cnt_i == '0 && out_act_i));
  // R6
  rate_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_RATE && out_act_i && !evt_i && !start_i) |=> !out_act_i);
  // R11
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && irq_en_i) |=> flag_i);
  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_i && !(evt_i && irq_en_i)) |=> !flag_i);
endmodule

bind dual_byte_timer dual_byte_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_w), .start_i(start_w),
  .evt_i(evt_w), .mode_i(mode_w), .cnt_i(cnt_w), .reload_i(reload_w),
  .out_act_i(out_act_w), .irq_en_i(irq_en_w), .flag_i(flag_w)
);

// File: tb/sim_dual_byte_timer.sv
module sim_dual_byte_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       trig = 1'b0;
  logic       tmr, irq;
  int         nchk = 0;
  int         nerr = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  dual_byte_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .trig_i(trig), .tmr_o(tmr), .irq_o(irq)
  );

  // {mode, tick select, reload, clocks from start to terminal event}
  localparam logic [35:0] VEC [7] = '{
    {2'd0, 2'd0, 16'd5,   16'd5},
    {2'd1, 2'd1, 16'd3,   16'd12},
    {2'd2, 2'd2, 16'd2,   16'd32},
    {2'd0, 2'd3, 16'd1,   16'd64},
    {2'd0, 2'd0, 16'd0,   16'd1},
    {2'd1, 2'd0, 16'd300, 16'd300},
    {2'd2, 2'd3, 16'd3,   16'd192}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller sits at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] s, input logic [15:0] rl,
                       input logic [7:0] aux);
    wr(2'd2, 8'h00);
    wr(2'd3, aux);
    wr(2'd0, rl[7:0]);
    wr(2'd1, rl[15:8]);
    wr(2'd2, {4'b0000, s, m});
    wr(2'd2, {4'b0001, s, m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int k;
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(2'd0, d); check("R1 lsb", d, 8'h00);
    rd(2'd1, d); check("R1 msb", d, 8'h00);
    rd(2'd2, d); check("R1 ctrl", d, 8'h00);
    rd(2'd3, d); check("R1 aux", d, 8'h06);
    check("R1 tmr_o", tmr, 1'b0);
    check("R1 irq_o", irq, 1'b0);

    // R2 reload bytes read back
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    rd(2'd0, d); check("R2 lsb", d, 8'h34);
    rd(2'd1, d); check("R2 msb", d, 8'h12);

    // R3 start needs identical config
    wr(2'd2, 8'h01);
    wr(2'd2, 8'h12);
    rd(2'd2, d); check("R3 mismatch keeps run low", d, 8'h02);
    wr(2'd2, 8'h12);
    rd(2'd2, d); check("R3 identical rewrite starts", d, 8'h12);
    wr(2'd2, 8'h02);

    // R4 vector table: terminal timing per mode and tick select
    for (int i = 0; i < 7; i++) begin
      setup(VEC[i][35:34], VEC[i][33:32], VEC[i][31:16], 8'h87);
      k = 0;
      while (irq == 1'b0 && k < 5000) begin
        step(1);
        k++;
      end
      check($sformatf("R4 vector %0d", i), k, VEC[i][15:0]);
    end

    // R9 / R10 snapshot and halt
    setup(2'd0, 2'd0, 16'd100, 8'h87);
    step(9);
    wr(2'd2, 8'h00);
    step(5);
    wr(2'd2, 8'h20);
    rd(2'd0, d); check("R9 snapshot low", d, 8'h5A);
    rd(2'd1, d); check("R9 snapshot high", d, 8'h00);
    step(10);
    wr(2'd2, 8'h20);
    rd(2'd0, d); check("R10 count held", d, 8'h5A);
    wr(2'd2, 8'h00);
    rd(2'd0, d); check("R2 reload after snapshot off", d, 8'h64);

    // R5 single-shot
    setup(2'd0, 2'd0, 16'd3, 8'h87);
    step(2); check("R5 before terminal", tmr, 1'b0);
    step(1); check("R5 at terminal", tmr, 1'b1);
    rd(2'd2, d); check("R5 run cleared", d, 8'h00);
    check("R11 flag set", irq, 1'b1);
    step(5); check("R5 output stays", tmr, 1'b1);
    wr(2'd2, 8'h20);
    rd(2'd0, d); check("R5 count zero", d, 8'h00);
    wr(2'd2, 8'h00);

    // R6 rate
    setup(2'd1, 2'd0, 16'd4, 8'h87);
    step(3); check("R6 idle", tmr, 1'b0);
    step(1); check("R6 pulse", tmr, 1'b1);
    step(1); check("R6 pulse one clock", tmr, 1'b0);
    step(3); check("R6 second pulse", tmr, 1'b1);

    // R7 square
    setup(2'd2, 2'd0, 16'd3, 8'h87);
    step(3); check("R7 first toggle", tmr, 1'b1);
    step(2); check("R7 holds", tmr, 1'b1);
    step(1); check("R7 second toggle", tmr, 1'b0);
    step(3); check("R7 third toggle", tmr, 1'b1);

    // R8 retriggerable
    setup(2'd3, 2'd0, 16'd5, 8'h87);
    step(3); check("R8 armed idle", tmr, 1'b0);
    trig = 1'b1; step(1); check("R8 trigger", tmr, 1'b1);
    trig = 1'b0; step(2);
    trig = 1'b1; step(1); check("R8 retrigger", tmr, 1'b1);
    trig = 1'b0; step(4); check("R8 extended", tmr, 1'b1);
    step(1); check("R8 terminal", tmr, 1'b0);

    // R11 masked, then clear
    setup(2'd0, 2'd0, 16'd2, 8'h86);
    step(4);
    check("R11 masked irq", irq, 1'b0);
    check("R11 event still ran", tmr, 1'b1);
    setup(2'd0, 2'd0, 16'd1, 8'h87);
    step(1); check("R11 enabled irq", irq, 1'b1);
    wr(2'd3, 8'h07); check("R11 no clear without bit7", irq, 1'b1);
    wr(2'd3, 8'h87); check("R11 cleared", irq, 1'b0);
    rd(2'd3, d); check("R11 aux flag bit", d, 8'h07);

    // R12 polarity
    wr(2'd3, 8'h81);
    check("R12 irq inverted", irq, 1'b1);
    check("R12 tmr inverted", tmr, 1'b0);
    setup(2'd0, 2'd0, 16'd1, 8'h81);
    check("R12 tmr idle inverted", tmr, 1'b1);
    step(1);
    check("R12 tmr active low", tmr, 1'b0);
    check("R12 irq active low", irq, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule